// File: doc/BRIEF.md
# Full-Raster Video Stream Encoder

This block turns a parallel video timing interface into a full-raster AXI4-Stream. Every input beat carries PIP pixels, each with SYM colour samples of BPS bits. The pixels come with per-pixel data enable, horizontal and vertical sync or blank flags, and one field flag per beat. Each pixel leaves in its own byte-rounded slot. The slot holds the colour samples and one extra control symbol whose top seven bits carry the timing flags. The block also produces start-of-frame and end-of-line markers, and it drives TUSER[0] and TLAST so that they match those markers.

A beat counter tracks the horizontal position inside the total raster line, whose length in beats is set on `cfg_line_beats`. After the vertical signal goes active, a start-of-frame flag is armed and lands on the first pixel of the next line that begins. A two-bit polarity register states whether the horizontal and vertical inputs are active low. The block reports both flags active high in the stream.

The output stage is a two-state machine. `ST_IDLE` holds no beat and accepts input freely. `ST_HOLD` presents a beat. The transitions are:
- `ST_IDLE` to `ST_HOLD` when an input beat is accepted.
- `ST_HOLD` to `ST_HOLD` while the sink stalls, or when it takes the beat and a new one arrives in the same cycle.
- `ST_HOLD` to `ST_IDLE` when the sink takes the beat and no new input is offered.

Top module: `fr_encoder`

## Requirements
- R1: The slot width is max(2, ceil(BPS*(SYM+1)/8)) bytes, and TDATA is PIP slots wide. Lane l occupies TDATA[l*SLOT_W +: SLOT_W], and input pixel l goes to lane l. Inside a slot, colour sample k sits at bits [k*BPS +: BPS] and the control symbol sits at bits [SYM*BPS +: BPS].
- R2: Control symbol bits from the top down are:
  - BPS-1: field
  - BPS-2: vertical
  - BPS-3: horizontal
  - BPS-4: data enable
  - BPS-5: mode
  - BPS-6: start of frame
  - BPS-7: end of line
- R3: Control bits BPS-8..0 are zero. Every slot bit above the control symbol is zero.
- R4: The mode bit equals `cfg_blank_mode`: 0 means the sync flags are carried, 1 means the blank flags are carried.
- R5: Writing `reg_wdata` with `reg_we` sets the polarity register, and `reg_rdata` returns it. Bit 0 set means the horizontal input is active low. Bit 1 set means the vertical input is active low. The stream flags are the input XOR that bit.
- R6: End of line is set only in lane PIP-1 of the beat numbered `cfg_line_beats` within each line. TLAST equals that bit.
- R7: Start of frame is set only in lane 0 of two kinds of beat: the first beat after reset, and the first beat of the first line that starts at or after a beat whose corrected lane-0 vertical flag rose from the previous accepted beat. TUSER equals that bit.
- R8: The field bit equals `in_field` for every lane of the beat.
- R9: While `m_tvalid` is high and `m_tready` is low, TDATA, TLAST and TUSER hold, `in_ready` is low, and the raster position does not advance.
- R10: After reset the machine is in `ST_IDLE`, with `m_tvalid` low and `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_pix | input | PIP*SYM*BPS | Colour samples, pixel 0 in the low bits |
| in_de | input | PIP | Data enable per pixel |
| in_hs | input | PIP | Horizontal sync/blank per pixel, raw polarity |
| in_vs | input | PIP | Vertical sync/blank per pixel, raw polarity |
| in_field | input | 1 | Field of this beat |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| cfg_blank_mode | input | 1 | 1 = blank flags carried, 0 = sync flags |
| cfg_line_beats | input | LW | Total raster line length in beats (at least 1) |
| reg_we | input | 1 | Polarity register write strobe |
| reg_wdata | input | 2 | Polarity write data |
| reg_rdata | output | 2 | Polarity register readback |
| m_tdata | output | PIP*SLOT_W | Stream data |
| m_tvalid | output | 1 | Stream valid |
| m_tready | input | 1 | Stream ready |
| m_tlast | output | 1 | End of raster line |
| m_tuser | output | 1 | Start of frame |

## Verification
Several line patterns are sent in turn:
- Plain lines show that end of line recurs on every fourth beat and that start of frame appears only once after reset.
- A vertical rise in the middle of a line is compared with a rise on a line's first beat. This separates the deferred start of frame from an immediate one.
- With the polarity register inverted, a raw-high vertical input must not arm a frame, while a raw-low one must. This tells a correct polarity XOR apart from one that is ignored.

Other beats carry distinct colour values, data-enable masks, the mode bit and the field bit, so that any swapped slot or flag shows up in the full TDATA compare. A stalled beat checks that data holds and that the line position does not move.

// File: rtl/fr_pkg.sv
package fr_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } fr_state_e;

    // Timing flags, most significant first, as they sit at the top of the control symbol
    typedef struct packed {
        logic field;
        logic vert;
        logic horiz;
        logic de;
        logic mode;
        logic sof;
        logic eol;
    } fr_flags_t;

    function automatic int slot_bytes(input int bps, input int sym);
        int b;
        b = (bps * (sym + 1) + 7) / 8;
        return (b < 2) ? 2 : b;
    endfunction

endpackage

// File: rtl/fr_ctrl_sym.sv
module fr_ctrl_sym
    import fr_pkg::*;
#(
    parameter int BPS = 10
) (
    input  fr_flags_t        flags,
    output logic [BPS-1:0]   sym
);
    localparam int RSV_W = BPS - 7;

    assign sym = {flags, {RSV_W{1'b0}}};

endmodule

// File: rtl/fr_polreg.sv
module fr_polreg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [1:0] wdata,
    output logic [1:0] pol
);
    always_ff @(posedge clk) begin
        if (!rst_n)  pol <= 2'b00;
        else if (we) pol <= wdata;
    end
endmodule

// File: rtl/fr_raster.sv
module fr_raster #(
    parameter int LW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          v_lvl,
    input  logic [LW-1:0] line_beats,
    output logic          sof,
    output logic          eol
);
    logic [LW-1:0] xb;
    logic          arm;
    logic          v_prev;
    logic          vedge;

    always_comb begin
        eol   = (xb == line_beats - LW'(1));
        vedge = v_lvl && !v_prev;
        sof   = (xb == '0) && (arm || vedge);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xb     <= '0;
            arm    <= 1'b1;
            v_prev <= 1'b0;
        end else if (adv) begin
            xb     <= eol ? '0 : xb + LW'(1);
            v_prev <= v_lvl;
            if (sof)        arm <= 1'b0;
            else if (vedge) arm <= 1'b1;
        end
    end
endmodule

// File: rtl/fr_encoder.sv
module fr_encoder
    import fr_pkg::*;
#(
    parameter int PIP = 2,
    parameter int SYM = 2,
    parameter int BPS = 10,
    parameter int LW  = 12,
    localparam int SLOT_W = slot_bytes(BPS, SYM) * 8,
    localparam int PIX_W  = SYM * BPS,
    localparam int TW     = PIP * SLOT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PIP*PIX_W-1:0] in_pix,
    input  logic [PIP-1:0]       in_de,
    input  logic [PIP-1:0]       in_hs,
    input  logic [PIP-1:0]       in_vs,
    input  logic                 in_field,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 cfg_blank_mode,
    input  logic [LW-1:0]        cfg_line_beats,
    input  logic                 reg_we,
    input  logic [1:0]           reg_wdata,
    output logic [1:0]           reg_rdata,
    output logic [TW-1:0]        m_tdata,
    output logic                 m_tvalid,
    input  logic                 m_tready,
    output logic                 m_tlast,
    output logic                 m_tuser
);
    fr_state_e   state, state_nx;
    logic        load;
    logic [1:0]  pol;
    logic        r_sof, r_eol;
    logic [TW-1:0] beat;

    fr_polreg u_pol (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .wdata (reg_wdata),
        .pol   (pol)
    );
    assign reg_rdata = pol;

    assign in_ready = (state == ST_IDLE) || m_tready;
    assign load     = in_valid && in_ready;

    fr_raster #(.LW(LW)) u_raster (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (load),
        .v_lvl      (in_vs[0] ^ pol[1]),
        .line_beats (cfg_line_beats),
        .sof        (r_sof),
        .eol        (r_eol)
    );

    for (genvar l = 0; l < PIP; l++) begin : g_lane
        fr_flags_t        fl;
        logic [BPS-1:0]   ctrl;
        logic [SLOT_W-1:0] slot;

        always_comb begin
            fl.field = in_field;
            fl.vert  = in_vs[l] ^ pol[1];
            fl.horiz = in_hs[l] ^ pol[0];
            fl.de    = in_de[l];
            fl.mode  = cfg_blank_mode;
            fl.sof   = (l == 0)       ? r_sof : 1'b0;
            fl.eol   = (l == PIP - 1) ? r_eol : 1'b0;
        end

        fr_ctrl_sym #(.BPS(BPS)) u_ctrl (
            .flags (fl),
            .sym   (ctrl)
        );

        always_comb begin
            slot              = '0;
            slot[PIX_W-1:0]   = in_pix[l*PIX_W +: PIX_W];
            slot[PIX_W +: BPS] = ctrl;
        end

        assign beat[l*SLOT_W +: SLOT_W] = slot;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (load)                    state_nx = ST_HOLD;
            ST_HOLD: if (m_tready && !in_valid)   state_nx = ST_IDLE;
            default:                              state_nx = ST_IDLE;
        endcase
    end

    // Output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_tdata <= '0;
            m_tlast <= 1'b0;
            m_tuser <= 1'b0;
        end else if (load) begin
            m_tdata <= beat;
            m_tlast <= r_eol;
            m_tuser <= r_sof;
        end
    end

    assign m_tvalid = (state == ST_HOLD);

endmodule

// File: rtl/fr_encoder_chk.sv
module fr_encoder_chk #(
    parameter int PIP = 2,
    parameter int SYM = 2,
    parameter int BPS = 10,
    localparam int SLOT_W = fr_pkg::slot_bytes(BPS, SYM) * 8,
    localparam int TW     = PIP * SLOT_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic [TW-1:0] m_tdata,
    input logic          m_tvalid,
    input logic          m_tready,
    input logic          m_tlast,
    input logic          m_tuser,
    input logic          in_ready
);
    localparam int CBASE = SYM * BPS;

    function automatic logic [TW-1:0] rsv_mask();
        logic [TW-1:0] m;
        m = '0;
        for (int l = 0; l < PIP; l++)
            for (int i = 0; i < SLOT_W; i++)
                if ((i >= CBASE && i < CBASE + BPS - 7) || i >= CBASE + BPS)
                    m[l*SLOT_W + i] = 1'b1;
        return m;
    endfunction

    function automatic logic [TW-1:0] low_eol_mask();
        logic [TW-1:0] m;
        m = '0;
        for (int l = 0; l < PIP - 1; l++)
            m[l*SLOT_W + CBASE + BPS - 7] = 1'b1;
        return m;
    endfunction

    localparam logic [TW-1:0] RSV  = rsv_mask();
    localparam logic [TW-1:0] LEOL = low_eol_mask();
    localparam int LAST_EOL = (PIP - 1) * SLOT_W + CBASE + BPS - 7;
    localparam int SOF0     = CBASE + BPS - 6;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast))); // R9
    AST_STALL_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |-> !in_ready); // R9
    AST_LAST_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> (m_tlast == m_tdata[LAST_EOL])); // R6
    AST_EOL_TOP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> ((m_tdata & LEOL) == '0)); // R6
    AST_USER_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> (m_tuser == m_tdata[SOF0])); // R7
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> ((m_tdata & RSV) == '0)); // R3
    AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !m_tvalid |-> in_ready); // R10
endmodule

bind fr_encoder fr_encoder_chk #(.PIP(PIP), .SYM(SYM), .BPS(BPS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .m_tdata  (m_tdata),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tlast  (m_tlast),
    .m_tuser  (m_tuser),
    .in_ready (in_ready)
);

// File: tb/fr_encoder_test.sv
`timescale 1ns/1ps
module fr_encoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] in_pix = '0;
    logic [1:0]  in_de = '0, in_hs = '0, in_vs = '0;
    logic        in_field = 1'b0, in_valid = 1'b0;
    logic        in_ready;
    logic        cfg_blank_mode = 1'b0;
    logic [11:0] cfg_line_beats = 12'd4;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_wdata = '0, reg_rdata;
    logic [63:0] m_tdata;
    logic        m_tvalid, m_tlast, m_tuser;
    logic        m_tready = 1'b1;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic pol_h = 1'b0, pol_v = 1'b0;

    always #2 clk = ~clk;

    fr_encoder uut (
        .clk(clk), .rst_n(rst_n), .in_pix(in_pix), .in_de(in_de), .in_hs(in_hs),
        .in_vs(in_vs), .in_field(in_field), .in_valid(in_valid), .in_ready(in_ready),
        .cfg_blank_mode(cfg_blank_mode), .cfg_line_beats(cfg_line_beats),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tlast(m_tlast), .m_tuser(m_tuser)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [39:0] pix_of(input int n);
        logic [9:0] b;
        b = 10'(n);
        return {b ^ 10'h155, b + 10'd7, ~b, b};
    endfunction

    // R1/R2/R3 layout, computed for PIP=2, SYM=2, BPS=10 (4-byte slots)
    function automatic logic [63:0] exp_beat(input logic [39:0] p, input logic [1:0] de,
        input logic [1:0] h, input logic [1:0] v, input logic fld, input logic md,
        input logic sof, input logic eol);
        logic [9:0] c0, c1;
        c0 = {fld, v[0], h[0], de[0], md, sof, 1'b0, 3'b000};
        c1 = {fld, v[1], h[1], de[1], md, 1'b0, eol, 3'b000};
        return {2'b00, c1, p[39:20], 2'b00, c0, p[19:0]};
    endfunction

    task automatic drive(input int n, input logic [1:0] de, hs, vs, input logic fld);
        in_pix = pix_of(n); in_de = de; in_hs = hs; in_vs = vs; in_field = fld;
    endtask

    function automatic logic [63:0] exp_of(input int n, input logic [1:0] de, hs, vs,
        input logic fld, input logic sof, input logic eol);
        return exp_beat(pix_of(n), de, hs ^ {2{pol_h}}, vs ^ {2{pol_v}}, fld,
                        cfg_blank_mode, sof, eol);
    endfunction

    task automatic send(input int n, input logic [1:0] de, hs, vs, input logic fld,
                        input logic xsof, input logic xeol, input string req);
        @(negedge clk);
        drive(n, de, hs, vs, fld);
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check({63'd0, m_tvalid}, 64'd1, {req, " tvalid"});
        check(m_tdata, exp_of(n, de, hs, vs, fld, xsof, xeol), {req, " tdata"});
        check({63'd0, m_tlast}, {63'd0, xeol}, {req, " tlast R6"});
        check({63'd0, m_tuser}, {63'd0, xsof}, {req, " tuser R7"});
    endtask

    task automatic send_line(input int base, input logic [1:0] vs0, vs_rest,
                             input logic sof0, input logic [1:0] de, hs,
                             input logic fld, input string req);
        send(base, de, hs, vs0, fld, sof0, 1'b0, req);
        for (int b = 1; b < 4; b++)
            send(base + b, de, hs, vs_rest, fld, 1'b0, b == 3, req);
    endtask

    task automatic reg_write(input logic [1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
        pol_h = d[0]; pol_v = d[1];
        check({62'd0, reg_rdata}, {62'd0, d}, "R5 readback");
    endtask

    task automatic t_reset();
        check({63'd0, m_tvalid}, 64'd0, "R10 reset tvalid");
        check({63'd0, in_ready}, 64'd1, "R10 reset in_ready");
        check({62'd0, reg_rdata}, 64'd0, "R5 reset polarity");
    endtask

    task automatic t_lines();
        send_line(16, 2'b00, 2'b00, 1'b1, 2'b11, 2'b00, 1'b0, "R1 R2 R3 R7 first line");
        send_line(32, 2'b00, 2'b00, 1'b0, 2'b01, 2'b10, 1'b0, "R2 R6 second line");
    endtask

    task automatic t_vedge();
        send(48, 2'b11, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, "R7 pre-edge");
        send(49, 2'b11, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, "R7 pre-edge");
        send(50, 2'b11, 2'b00, 2'b01, 1'b0, 1'b0, 1'b0, "R7 edge mid-line");
        send(51, 2'b11, 2'b00, 2'b01, 1'b0, 1'b0, 1'b1, "R7 edge mid-line");
        send_line(64, 2'b01, 2'b01, 1'b1, 2'b10, 2'b00, 1'b0, "R7 deferred sof");
        send_line(80, 2'b00, 2'b00, 1'b0, 2'b10, 2'b00, 1'b0, "R7 no repeat");
        send_line(96, 2'b01, 2'b01, 1'b1, 2'b00, 2'b01, 1'b0, "R7 edge on first beat");
    endtask

    task automatic t_polarity();
        reg_write(2'b11);
        send_line(112, 2'b11, 2'b11, 1'b0, 2'b11, 2'b10, 1'b0, "R5 inverted inactive");
        send_line(128, 2'b10, 2'b10, 1'b1, 2'b11, 2'b01, 1'b0, "R5 inverted edge");
        reg_write(2'b00);
    endtask

    task automatic t_mode();
        cfg_blank_mode = 1'b1;
        send_line(144, 2'b00, 2'b00, 1'b0, 2'b01, 2'b11, 1'b0, "R4 blank mode");
        cfg_blank_mode = 1'b0;
    endtask

    task automatic t_stall();
        logic [63:0] ea, eb;
        ea = exp_of(160, 2'b11, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0);
        eb = exp_of(161, 2'b10, 2'b01, 2'b00, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        m_tready = 1'b0;
        drive(160, 2'b11, 2'b00, 2'b00, 1'b0);
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        drive(161, 2'b10, 2'b01, 2'b00, 1'b0);
        check({63'd0, in_ready}, 64'd0, "R9 stalled in_ready");
        check(m_tdata, ea, "R9 first beat held");
        @(posedge clk);
        @(negedge clk);
        check(m_tdata, ea, "R9 still held");
        check({63'd0, m_tvalid}, 64'd1, "R9 valid held");
        m_tready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(m_tdata, eb, "R9 next beat after release");
        send(162, 2'b11, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, "R9 position");
        send(163, 2'b11, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, "R9 eol not shifted");
    endtask

    task automatic t_field();
        send_line(176, 2'b00, 2'b00, 1'b0, 2'b11, 2'b00, 1'b1, "R8 second field");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lines();
        t_vedge();
        t_polarity();
        t_mode();
        t_stall();
        t_field();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule